// File: doc/BRIEF.md
# Dual-Channel Serial Frame Sync Generator

This block is the master-side timing and transfer engine of a two-channel serial port. It divides the core clock down to a serial clock and produces one frame sync line that both data channels share, so channel A and channel B always begin a 32-bit word together. Both channels run in one direction at a time. In transmit mode each channel takes words from the host into a two-word buffer and shifts them out MSB first. In receive mode each channel assembles incoming bits into words and queues them for the host.

Frame syncs come from one of two schedules. In the fixed-period schedule a pulse is issued every programmed number of serial clocks, whatever the buffers hold. A transmit channel with nothing new sends its previous word again and raises a sticky underflow flag. A receive channel whose buffer is full drops the incoming word and raises a sticky overflow flag. In the buffer-gated schedule a pulse is issued only when both channels can take part: both transmit buffers hold a word, or neither receive buffer is full. Each channel raises a service request for more data or to be emptied. A per-channel select bit steers that request to a DMA request line or to an interrupt line.

Top module: `dual_fsync_port`

## Requirements
- R1: While enabled, `sclk` starts low and toggles every (divisor[15:0] + 1) core clocks; it is held low while `en` is low.
- R2: `fs` and `sd_out` change only on the core edge where `sclk` falls. `fs` stays high for exactly one serial clock period. That period carries bit 31 of the word on both `sd_out[0]` (channel A) and `sd_out[1]` (channel B), and bits 30 down to 0 follow on the next 31 periods.
- R3: With `rx_mode`=0 and `di_mode`=0, a frame sync is issued only when both transmit buffers hold at least one word. While both keep data, frames run back to back with frame syncs 32 serial clocks apart.
- R4: With `rx_mode`=1 and `di_mode`=0, a frame sync is issued only when neither receive buffer is full. Frames resume once the host frees a slot.
- R5: With `di_mode`=1, a frame sync is issued every (divisor[31:16] + 1) serial clocks in either direction, whatever the buffers hold.
- R6: When a transmit frame starts on an empty buffer, that channel sends its previous word again and sets its bit of `underflow`, which stays set until `en` is cleared.
- R7: In receive mode `sd_in` is sampled on `sclk` rising edges, MSB first, starting in the frame sync period. Each completed word is queued, `rd_data_a`/`rd_data_b` show the oldest queued word, and a `rd_pop` bit removes it.
- R8: A received word that completes while its buffer is full is dropped, the queued words are kept, and the channel's `overflow` bit is set and stays set until `en` is cleared.
- R9: The service request of a channel is "buffer not full" in transmit mode and "buffer not empty" in receive mode. It appears one core clock later on `dma_req[ch]` when `dma_en[ch]`=1 and on `irq[ch]` when `dma_en[ch]`=0.
- R10: Clearing `en` empties both buffers and clears the counters, `fs`, `sd_out`, `underflow`, `overflow`, `dma_req` and `irq`.
- R11: A host write into a full transmit buffer is ignored and leaves the queued words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low clears the block |
| rx_mode | input | 1 | 0 = both channels transmit, 1 = both receive |
| di_mode | input | 1 | 0 = buffer-gated frame sync, 1 = fixed-period frame sync |
| divisor | input | 32 | [15:0] serial clock divisor, [31:16] frame period divisor |
| dma_en | input | 2 | Per-channel request routing: 1 = DMA line, 0 = interrupt line |
| wr_en | input | 2 | Per-channel host write strobe (transmit mode) |
| wr_data_a | input | 32 | Host write word for channel A |
| wr_data_b | input | 32 | Host write word for channel B |
| rd_pop | input | 2 | Per-channel host read strobe (receive mode) |
| rd_data_a | output | 32 | Oldest received word of channel A |
| rd_data_b | output | 32 | Oldest received word of channel B |
| sd_in | input | 2 | Serial data in, bit 0 channel A, bit 1 channel B |
| sclk | output | 1 | Shared serial clock |
| fs | output | 1 | Shared frame sync |
| sd_out | output | 2 | Serial data out, bit 0 channel A, bit 1 channel B |
| dma_req | output | 2 | Per-channel DMA service request |
| irq | output | 2 | Per-channel interrupt service request |
| underflow | output | 2 | Sticky per-channel transmit underflow |
| overflow | output | 2 | Sticky per-channel receive overflow |

## Verification
The hardest states to reach from the ports are the ones where the two channels disagree: one transmit buffer full while the other is empty, and a receive port stalled with both buffers full. The stimulus fills channel A alone, including one extra write that must be dropped, and holds it there for many serial clocks to show that no frame starts. Only then does it feed channel B and follow the two frames that result. For receive, the bench acts as an external transmitter that answers every frame sync with a new pair of words and never pops. This drives the buffer-gated mode into a stall and the fixed-period mode into overflow, and single pops then show the queue order and the resumed frames.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic {
    SCHED_GATED = 1'b0,
    SCHED_FIXED = 1'b1
  } fs_sched_e;

  function automatic logic [15:0] sclk_field(input logic [31:0] d);
    return d[15:0];
  endfunction

  function automatic logic [15:0] frame_field(input logic [31:0] d);
    return d[31:16];
  endfunction
endpackage

// File: rtl/fsg_clkdiv.sv
module fsg_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = en && !rst && (cnt == div);
  assign rise_tick = wrap && !sclk;
  assign fall_tick = wrap && sclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= !sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsg_framer.sv
module fsg_framer
  import fsg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  fs_sched_e        sched,
  input  logic [DIV_W-1:0] frame_div,
  input  logic             ready,
  input  logic             rise_tick,
  input  logic             fall_tick,
  output logic             fs,
  output logic             fire,
  output logic             shift,
  output logic             sample,
  output logic             word_done
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [DIV_W-1:0] per_cnt;
  logic [CW-1:0]    tx_left;
  logic [CW-1:0]    rx_left;
  logic             fixed_due;
  logic             gated_due;

  assign fixed_due = (per_cnt == '0);
  assign gated_due = (tx_left == '0) && ready;
  assign fire      = fall_tick && ((sched == SCHED_FIXED) ? fixed_due : gated_due);
  assign shift     = fall_tick && !fire && (tx_left != '0);
  assign sample    = rise_tick && (rx_left != '0);
  assign word_done = sample && (rx_left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      fs      <= 1'b0;
      per_cnt <= '0;
      tx_left <= '0;
      rx_left <= '0;
    end else begin
      if (fall_tick) begin
        fs <= fire;
        if (sched == SCHED_FIXED) begin
          per_cnt <= fixed_due ? frame_div : per_cnt - 1'b1;
        end
      end
      if (fire) begin
        tx_left <= CW'(WORD_W - 1);
        rx_left <= CW'(WORD_W);
      end else begin
        if (shift) begin
          tx_left <= tx_left - 1'b1;
        end
        if (sample) begin
          rx_left <= rx_left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsg_fifo.sv
module fsg_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [NW-1:0] count;
  logic          do_wr;
  logic          do_rd;

  assign full  = (count == NW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem[wptr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) begin
        wptr <= bump(wptr);
      end
      if (do_rd) begin
        rptr <= bump(rptr);
      end
      if (do_wr && !do_rd) begin
        count <= count + 1'b1;
      end else if (do_rd && !do_wr) begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsg_lane.sv
module fsg_lane #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         rx_mode,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  input  logic         host_pop,
  output logic [W-1:0] host_rdata,
  input  logic         fire,
  input  logic         shift,
  input  logic         sample,
  input  logic         word_done,
  input  logic         sd_in,
  output logic         sd_out,
  output logic         full,
  output logic         empty,
  output logic         udf,
  output logic         ovf
);
  logic         clr;
  logic         tx_load;
  logic         q_wr;
  logic         q_rd;
  logic [W-1:0] q_wdata;
  logic [W-1:0] tx_sh;
  logic [W-1:0] last_word;
  logic [W-1:0] next_word;
  logic [W-1:0] rx_sh;
  logic [W-1:0] rx_word;

  assign clr     = rst || !en;
  assign tx_load = fire && !rx_mode;
  assign rx_word = {rx_sh[W-2:0], sd_in};
  assign q_wr    = rx_mode ? (word_done && en) : (host_wr && en);
  assign q_wdata = rx_mode ? rx_word : host_wdata;
  assign q_rd    = rx_mode ? host_pop : tx_load;

  fsg_fifo #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk  (clk),
    .clr  (clr),
    .wr   (q_wr),
    .wdata(q_wdata),
    .rd   (q_rd),
    .rdata(host_rdata),
    .full (full),
    .empty(empty)
  );

  assign next_word = empty ? last_word : host_rdata;
  assign sd_out    = tx_sh[W-1];

  always_ff @(posedge clk) begin
    if (clr) begin
      tx_sh     <= '0;
      last_word <= '0;
      udf       <= 1'b0;
    end else if (tx_load) begin
      tx_sh     <= next_word;
      last_word <= next_word;
      if (empty) begin
        udf <= 1'b1;
      end
    end else if (shift && !rx_mode) begin
      tx_sh <= {tx_sh[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rx_sh <= '0;
      ovf   <= 1'b0;
    end else if (rx_mode && sample) begin
      rx_sh <= rx_word;
      if (word_done && full) begin
        ovf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_fsync_port.sv
module dual_fsync_port
  import fsg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 2,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rx_mode,
  input  logic              di_mode,
  input  logic [31:0]       divisor,
  input  logic [1:0]        dma_en,
  input  logic [1:0]        wr_en,
  input  logic [WORD_W-1:0] wr_data_a,
  input  logic [WORD_W-1:0] wr_data_b,
  input  logic [1:0]        rd_pop,
  output logic [WORD_W-1:0] rd_data_a,
  output logic [WORD_W-1:0] rd_data_b,
  input  logic [1:0]        sd_in,
  output logic              sclk,
  output logic              fs,
  output logic [1:0]        sd_out,
  output logic [1:0]        dma_req,
  output logic [1:0]        irq,
  output logic [1:0]        underflow,
  output logic [1:0]        overflow
);
  logic              rise_tick;
  logic              fall_tick;
  logic              fire;
  logic              shift;
  logic              sample;
  logic              word_done;
  logic              ready;
  logic [NCH-1:0]    fifo_full;
  logic [NCH-1:0]    fifo_empty;
  logic [NCH-1:0]    svc_req;
  logic [WORD_W-1:0] wdat [NCH];
  logic [WORD_W-1:0] rdat [NCH];
  fs_sched_e         sched;

  assign sched   = di_mode ? SCHED_FIXED : SCHED_GATED;
  assign wdat[0] = wr_data_a;
  assign wdat[1] = wr_data_b;
  assign rd_data_a = rdat[0];
  assign rd_data_b = rdat[1];

  assign ready   = rx_mode ? (&(~fifo_full)) : (&(~fifo_empty));
  assign svc_req = rx_mode ? ~fifo_empty : ~fifo_full;

  fsg_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .div      (DIV_W'(sclk_field(divisor))),
    .sclk     (sclk),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  fsg_framer #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_frm (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sched    (sched),
    .frame_div(DIV_W'(frame_field(divisor))),
    .ready    (ready),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick),
    .fs       (fs),
    .fire     (fire),
    .shift    (shift),
    .sample   (sample),
    .word_done(word_done)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    fsg_lane #(.W(WORD_W), .DEPTH(DEPTH)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .rx_mode   (rx_mode),
      .host_wr   (wr_en[ch]),
      .host_wdata(wdat[ch]),
      .host_pop  (rd_pop[ch]),
      .host_rdata(rdat[ch]),
      .fire      (fire),
      .shift     (shift),
      .sample    (sample),
      .word_done (word_done),
      .sd_in     (sd_in[ch]),
      .sd_out    (sd_out[ch]),
      .full      (fifo_full[ch]),
      .empty     (fifo_empty[ch]),
      .udf       (underflow[ch]),
      .ovf       (overflow[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      dma_req <= '0;
      irq     <= '0;
    end else begin
      dma_req <= svc_req & dma_en;
      irq     <= svc_req & ~dma_en;
    end
  end
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       rx_mode,
  input logic       di_mode,
  input logic [1:0] dma_en,
  input logic       sclk,
  input logic       fs,
  input logic [1:0] sd_out,
  input logic [1:0] dma_req,
  input logic [1:0] irq,
  input logic [1:0] underflow,
  input logic [1:0] overflow,
  input logic [1:0] fifo_empty,
  input logic [1:0] fifo_full
);
  // R1: serial clock parked low while disabled
  a_r1_sclk_parked: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sclk);

  // R2: frame sync moves only with a falling serial clock
  a_r2_fs_on_fall: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(fs)) |-> $fell(sclk));

  // R2: serial data moves only with a falling serial clock
  a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(sd_out)) |-> $fell(sclk));

  // R3: gated transmit frame needs both buffers loaded
  a_r3_tx_gate: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !di_mode && !rx_mode && $rose(fs))
      |-> $past(fifo_empty == 2'b00));

  // R4: gated receive frame needs room in both buffers
  a_r4_rx_gate: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !di_mode && rx_mode && $rose(fs))
      |-> $past(fifo_full == 2'b00));

  // R6: underflow is sticky while enabled
  a_r6_udf_sticky: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> ((underflow & $past(underflow)) == $past(underflow)));

  // R8: overflow is sticky while enabled
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> ((overflow & $past(overflow)) == $past(overflow)));

  // R9: requests land only on the selected line
  a_r9_routing: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |->
      (((dma_req & ~$past(dma_en)) == 2'b00) && ((irq & $past(dma_en)) == 2'b00)));

  // R10: disabling clears outputs and flags
  a_r10_disable_clear: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!fs && (underflow == 2'b00) && (overflow == 2'b00)
             && (dma_req == 2'b00) && (irq == 2'b00)));
endmodule

bind dual_fsync_port fsg_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .rx_mode   (rx_mode),
  .di_mode   (di_mode),
  .dma_en    (dma_en),
  .sclk      (sclk),
  .fs        (fs),
  .sd_out    (sd_out),
  .dma_req   (dma_req),
  .irq       (irq),
  .underflow (underflow),
  .overflow  (overflow),
  .fifo_empty(fifo_empty),
  .fifo_full (fifo_full)
);

// File: tb/dual_fsync_port_test.sv
`timescale 1ns/1ps
module dual_fsync_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        rx_mode = 1'b0;
  logic        di_mode = 1'b0;
  logic [31:0] divisor = '0;
  logic [1:0]  dma_en = '0;
  logic [1:0]  wr_en = '0;
  logic [31:0] wr_data_a = '0;
  logic [31:0] wr_data_b = '0;
  logic [1:0]  rd_pop = '0;
  logic [31:0] rd_data_a;
  logic [31:0] rd_data_b;
  logic [1:0]  sd_in = '0;
  logic        sclk;
  logic        fs;
  logic [1:0]  sd_out;
  logic [1:0]  dma_req;
  logic [1:0]  irq;
  logic [1:0]  underflow;
  logic [1:0]  overflow;

  always #4 clk = ~clk;

  dual_fsync_port uut (
    .clk(clk), .rst(rst), .en(en), .rx_mode(rx_mode), .di_mode(di_mode),
    .divisor(divisor), .dma_en(dma_en), .wr_en(wr_en),
    .wr_data_a(wr_data_a), .wr_data_b(wr_data_b), .rd_pop(rd_pop),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .sd_in(sd_in),
    .sclk(sclk), .fs(fs), .sd_out(sd_out), .dma_req(dma_req), .irq(irq),
    .underflow(underflow), .overflow(overflow)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  // {sclk divisor, word A, word B}
  localparam logic [79:0] VEC [4] = '{
    {16'd1, 32'hDEAD_BEEF, 32'h1234_5678},
    {16'd0, 32'h8000_0001, 32'h7FFF_FFFE},
    {16'd3, 32'hFFFF_FFFF, 32'h0000_0000},
    {16'd2, 32'hA5A5_5A5A, 32'h0F0F_F0F0}
  };

  function automatic logic [31:0] gen(input int ch, input int k);
    logic [31:0] kk;
    kk = 32'(k + 1);
    return (kk * 32'h9E37_79B9) ^ (ch != 0 ? 32'h5A5A_0F0F : 32'h0);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // serial-side monitor and external receive source
  logic sclk_p = 1'b0;
  logic fs_p = 1'b0;
  int   srise_cnt = 0;
  int   fs_rises = 0;
  int   fs_at = 0;
  int   fs_at_prev = 0;
  int   rx_k = -1;
  int   bitpos = 0;

  always @(negedge clk) begin
    if (sclk && !sclk_p) srise_cnt++;
    if (fs && !fs_p) begin
      fs_rises++;
      fs_at_prev = fs_at;
      fs_at = srise_cnt;
    end
    if (sclk_p && !sclk) begin
      if (fs) begin
        rx_k++;
        bitpos = 31;
      end else if (bitpos > 0) begin
        bitpos--;
      end
      if (rx_k >= 0) sd_in = {gen(1, rx_k)[bitpos], gen(0, rx_k)[bitpos]};
    end
    sclk_p = sclk;
    fs_p = fs;
  end

  task automatic wait_srise();
    logic p;
    p = sclk;
    @(negedge clk);
    while (!(sclk && !p)) begin
      p = sclk;
      @(negedge clk);
    end
  endtask

  task automatic wait_rises(input int n);
    for (int i = 0; i < n; i++) wait_srise();
  endtask

  task automatic configure(input logic rx, input logic di, input logic [15:0] cdiv,
                           input logic [15:0] fdiv, input logic [1:0] dma);
    @(negedge clk);
    en = 1'b0;
    rx_mode = rx;
    di_mode = di;
    divisor = {fdiv, cdiv};
    dma_en = dma;
    rx_k = -1;
    bitpos = 0;
    sd_in = '0;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic host_write(input logic [1:0] mask, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    wr_en = mask;
    wr_data_a = a;
    wr_data_b = b;
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic host_pop();
    @(negedge clk);
    rd_pop = 2'b11;
    @(negedge clk);
    rd_pop = 2'b00;
  endtask

  task automatic capture(output logic [31:0] a, output logic [31:0] b);
    int n;
    n = 0;
    a = '0;
    b = '0;
    wait_srise();
    while (!fs && n < 4000) begin
      wait_srise();
      n++;
    end
    for (int i = 31; i >= 0; i--) begin
      a[i] = sd_out[0];
      b[i] = sd_out[1];
      if (i > 0) wait_srise();
    end
  endtask

  task automatic measure_high(output int n);
    wait_srise();
    n = 1;
    @(negedge clk);
    while (sclk) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] ca, cb, ca2, cb2;
    int hi, base;

    // R10: reset and disabled state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "sclk idle", {31'd0, sclk}, 32'd0);
    check("R10", "fs idle", {31'd0, fs}, 32'd0);
    check("R10", "requests idle", {28'd0, dma_req, irq}, 32'd0);
    check("R10", "flags idle", {28'd0, underflow, overflow}, 32'd0);

    // R1 R2 R3: vector table, gated transmit, one frame each
    for (int v = 0; v < 4; v++) begin
      configure(1'b0, 1'b0, VEC[v][79:64], 16'd0, 2'b11);
      measure_high(hi);
      check("R1", $sformatf("sclk high time v%0d", v), 32'(hi), 32'(VEC[v][79:64]) + 32'd1);
      host_write(2'b11, VEC[v][63:32], VEC[v][31:0]);
      capture(ca, cb);
      check("R2", $sformatf("channel A word v%0d", v), ca, VEC[v][63:32]);
      check("R2", $sformatf("channel B word v%0d", v), cb, VEC[v][31:0]);
    end

    // R9 R3 R11: one-sided fill, extra write, then the other channel
    configure(1'b0, 1'b0, 16'd7, 16'd0, 2'b01);
    repeat (4) @(negedge clk);
    check("R9", "tx empty dma_req", {30'd0, dma_req}, 32'h1);
    check("R9", "tx empty irq", {30'd0, irq}, 32'h2);
    host_write(2'b01, 32'hA000_0000, 32'h0);
    host_write(2'b01, 32'hA111_1111, 32'h0);
    host_write(2'b01, 32'hA222_2222, 32'h0);
    repeat (3) @(negedge clk);
    check("R9", "A full drops dma_req", {30'd0, dma_req}, 32'h0);
    check("R9", "B empty keeps irq", {30'd0, irq}, 32'h2);
    base = fs_rises;
    wait_rises(100);
    check("R3", "no frame with B empty", 32'(fs_rises - base), 32'd0);
    host_write(2'b10, 32'h0, 32'hB000_0000);
    host_write(2'b10, 32'h0, 32'hB111_1111);
    capture(ca, cb);
    capture(ca2, cb2);
    check("R3", "frame 0 A", ca, 32'hA000_0000);
    check("R3", "frame 0 B", cb, 32'hB000_0000);
    check("R11", "frame 1 A keeps queued word", ca2, 32'hA111_1111);
    check("R3", "frame 1 B", cb2, 32'hB111_1111);
    check("R3", "back-to-back spacing", 32'(fs_at - fs_at_prev), 32'd32);
    wait_rises(100);
    check("R11", "no third frame", 32'(fs_rises - base), 32'd2);

    // R5 R6: fixed period transmit with a single word per channel
    configure(1'b0, 1'b1, 16'd1, 16'd39, 2'b00);
    host_write(2'b11, 32'hC0DE_0001, 32'h3C3C_A5A5);
    capture(ca, cb);
    check("R5", "fixed frame 0 A", ca, 32'hC0DE_0001);
    capture(ca2, cb2);
    check("R6", "repeat A on underflow", ca2, 32'hC0DE_0001);
    check("R6", "repeat B on underflow", cb2, 32'h3C3C_A5A5);
    check("R5", "fixed period 40 sclk", 32'(fs_at - fs_at_prev), 32'd40);
    check("R6", "underflow sticky", {30'd0, underflow}, 32'h3);
    check("R9", "tx irq routing", {28'd0, irq, dma_req}, 32'hC);

    // R4 R7: gated receive stalls on full buffers
    base = fs_rises;
    configure(1'b1, 1'b0, 16'd1, 16'd0, 2'b11);
    wait_rises(300);
    check("R4", "two frames then stall", 32'(fs_rises - base), 32'd2);
    check("R7", "rx head A", rd_data_a, gen(0, 0));
    check("R7", "rx head B", rd_data_b, gen(1, 0));
    check("R9", "rx dma_req", {30'd0, dma_req}, 32'h3);
    host_pop();
    check("R7", "rx second A", rd_data_a, gen(0, 1));
    check("R7", "rx second B", rd_data_b, gen(1, 1));
    wait_rises(200);
    check("R4", "frame resumes after pop", 32'(fs_rises - base), 32'd3);
    host_pop();
    check("R7", "rx third A", rd_data_a, gen(0, 2));

    // R8 R5: fixed period receive overflow
    base = fs_rises;
    configure(1'b1, 1'b1, 16'd0, 16'd31, 2'b00);
    wait_rises(200);
    check("R5", "fixed rx frames keep coming", {31'd0, (fs_rises - base) >= 5}, 32'd1);
    check("R8", "overflow set", {30'd0, overflow}, 32'h3);
    check("R8", "queued word kept A", rd_data_a, gen(0, 0));
    check("R8", "queued word kept B", rd_data_b, gen(1, 0));

    // R10: disable clears
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "flags cleared", {28'd0, underflow, overflow}, 32'd0);
    check("R10", "fs sclk low", {30'd0, fs, sclk}, 32'd0);
    configure(1'b1, 1'b0, 16'd200, 16'd0, 2'b11);
    repeat (4) @(negedge clk);
    check("R10", "rx buffers emptied", {30'd0, dma_req}, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule